// File: doc/BRIEF.md
# Time-over-threshold width calculator

This block turns the edge events of a single time-measuring channel into pulse widths. Each event carries a timestamp in two parts: a coarse count of system clock cycles and a calibrated fine time, in fine-time units (for example picoseconds). The absolute time of an edge is the coarse count times the clock period, minus the fine time. The clock period is a parameter expressed in fine-time units, so all arithmetic stays in integers.

A leading edge is held as pending. The next trailing edge is paired with it. The block then forms the trailing time minus the leading time and registers the result with a one-cycle valid pulse.

The coarse counter is free-running and wraps with a power-of-two period that is set by its width. A pair that straddles a wrap would give a negative difference. The block repairs this with one conditional addition of the full timestamp span, which is the modulus times the clock period. Several pulses per channel are handled one pair after another, with no gap needed between them. A trailing edge with no pending leading edge is discarded and raises a sticky error flag.

Top module: `tot_width_top`

## Requirements
- R1: While reset is held, and on release, `res_valid_o` and `orphan_err_o` are 0 and no leading edge is pending. Reset is asynchronous active-low and is released through a two-stage synchronizer.
- R2: An accepted trailing edge (`ev_valid_i`=1, `ev_trail_i`=1) that finds a pending leading edge raises `res_valid_o` for exactly one cycle, in the cycle after the trailing edge is sampled. `res_width_o` = (Ct−Cl)·CLK_FINE − Ft + Fl.
- R3: The coarse difference Ct−Cl is taken modulo 2^COARSE_W, so a pair whose coarse counter wrapped between its edges gives the true positive width.
- R4: When the difference is still negative, which happens with equal coarse counts and Ft > Fl, exactly one span SPAN = 2^COARSE_W·CLK_FINE is added.
- R5: A leading edge (`ev_trail_i`=0) that arrives while another leading edge is pending replaces the pending timestamp.
- R6: A trailing edge with no pending leading edge produces no result. It sets `orphan_err_o` in the next cycle, and the flag stays set until reset.
- R7: Pairing clears the pending state. Pulses can follow one another on consecutive cycles, and each one is paired independently.
- R8: A cycle with `ev_valid_i`=0 is ignored whatever the other event inputs carry: it produces no result and does not touch the error flag.
- R9: Every reported width lies in 0 … SPAN−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_trail_i | input | 1 | Edge kind: 1 = trailing, 0 = leading |
| ev_coarse_i | input | COARSE_W | Coarse clock-cycle count of the edge |
| ev_fine_i | input | FINE_W | Calibrated fine time of the edge |
| res_valid_o | output | 1 | One-cycle pulse marking a new width |
| res_width_o | output | OUT_W | Pulse width in fine-time units, OUT_W = clog2(SPAN+1) |
| orphan_err_o | output | 1 | Sticky flag for a trailing edge without a leading edge |

## Verification
The width arithmetic is exercised with several pair types, and each one isolates a different part of the calculation:
- a plain pair with a positive coarse gap;
- a pair across the coarse wrap, which checks the modulo coarse difference;
- a pair with equal coarse counts and a later fine time, which checks the single span addition;
- a zero-width pair;
- the maximum-span pair, which checks the upper bound.

The pairing logic is tried with a doubled leading edge, which separates replacement from keeping the first edge. Back-to-back pulses show that the pending state clears on each pairing. An orphan trailing edge, sent after a masked event, separates the effect of `ev_valid_i` from a real error.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/tot_pair_tracker.sv
module tot_pair_tracker
  import tot_pkg::*;
#(
  parameter int COARSE_W = 13,
  parameter int FINE_W   = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  edge_kind_e          ev_kind,
  input  logic [COARSE_W-1:0] ev_coarse,
  input  logic [FINE_W-1:0]   ev_fine,
  output logic                pend_o,
  output logic [COARSE_W-1:0] lead_coarse_o,
  output logic [FINE_W-1:0]   lead_fine_o,
  output logic                fire_o,
  output logic                orphan_o
);

  logic pend_q, pend_d;
  logic load_en;
  logic [COARSE_W-1:0] lead_c_q;
  logic [FINE_W-1:0]   lead_f_q;

  always_comb begin
    load_en  = ev_valid && (ev_kind == EDGE_LEAD);
    fire_o   = ev_valid && (ev_kind == EDGE_TRAIL) && pend_q;
    orphan_o = ev_valid && (ev_kind == EDGE_TRAIL) && !pend_q;
    pend_d   = pend_q;
    if (load_en)     pend_d = 1'b1;
    else if (fire_o) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      lead_c_q <= ev_coarse;
      lead_f_q <= ev_fine;
    end
  end

  assign pend_o        = pend_q;
  assign lead_coarse_o = lead_c_q;
  assign lead_fine_o   = lead_f_q;

  // R5
  lead_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EDGE_LEAD) |=> pend_o);

  // R7
  pair_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EDGE_TRAIL) |=> !pend_o);

endmodule

// File: rtl/tot_width_calc.sv
module tot_width_calc #(
  parameter int     COARSE_W = 13,
  parameter int     FINE_W   = 13,
  parameter int     CLK_FINE = 5000,
  parameter int     OUT_W    = 26,
  parameter longint SPAN     = 40960000
) (
  input  logic [COARSE_W-1:0] lead_c,
  input  logic [FINE_W-1:0]   lead_f,
  input  logic [COARSE_W-1:0] trail_c,
  input  logic [FINE_W-1:0]   trail_f,
  output logic [OUT_W-1:0]    width_o
);

  localparam int RAW_W = OUT_W + 1;
  localparam logic [OUT_W-1:0] SPAN_C = OUT_W'(SPAN);

  logic [COARSE_W-1:0]     dc;
  logic [OUT_W-1:0]        prod;
  logic signed [RAW_W-1:0] raw;
  logic signed [RAW_W-1:0] fixed;

  always_comb begin
    dc    = trail_c - lead_c;
    prod  = OUT_W'(dc) * OUT_W'(CLK_FINE);
    raw   = $signed({1'b0, prod}) + $signed(RAW_W'(lead_f))
          - $signed(RAW_W'(trail_f));
    fixed = raw[RAW_W-1] ? (raw + $signed({1'b0, SPAN_C})) : raw;
    width_o = fixed[OUT_W-1:0];
  end

endmodule

// File: rtl/tot_width_top.sv
module tot_width_top
  import tot_pkg::*;
#(
  parameter int COARSE_W = 13,
  parameter int FINE_W   = 13,
  parameter int CLK_FINE = 5000,
  localparam longint SPAN  = longint'(64'd1 << COARSE_W) * longint'(CLK_FINE),
  localparam int     OUT_W = $clog2(SPAN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid_i,
  input  logic                ev_trail_i,
  input  logic [COARSE_W-1:0] ev_coarse_i,
  input  logic [FINE_W-1:0]   ev_fine_i,
  output logic                res_valid_o,
  output logic [OUT_W-1:0]    res_width_o,
  output logic                orphan_err_o
);

  localparam logic [OUT_W-1:0] SPAN_M1 = OUT_W'(SPAN - 1);

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  edge_kind_e          kind;
  logic                pend, fire, orphan;
  logic [COARSE_W-1:0] lead_c;
  logic [FINE_W-1:0]   lead_f;
  logic [OUT_W-1:0]    width_c;

  assign kind = edge_kind_e'(ev_trail_i);

  tot_pair_tracker #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_pair (
    .clk           (clk),
    .rst_n         (rst_s),
    .ev_valid      (ev_valid_i),
    .ev_kind       (kind),
    .ev_coarse     (ev_coarse_i),
    .ev_fine       (ev_fine_i),
    .pend_o        (pend),
    .lead_coarse_o (lead_c),
    .lead_fine_o   (lead_f),
    .fire_o        (fire),
    .orphan_o      (orphan)
  );

  tot_width_calc #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .CLK_FINE (CLK_FINE),
    .OUT_W    (OUT_W),
    .SPAN     (SPAN)
  ) u_calc (
    .lead_c  (lead_c),
    .lead_f  (lead_f),
    .trail_c (ev_coarse_i),
    .trail_f (ev_fine_i),
    .width_o (width_c)
  );

  logic             vld_q, vld_d;
  logic             err_q, err_d;
  logic [OUT_W-1:0] width_q;

  always_comb begin
    vld_d = fire;
    err_d = err_q | orphan;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) width_q <= width_c;
  end

  assign res_valid_o  = vld_q;
  assign res_width_o  = width_q;
  assign orphan_err_o = err_q;

  // R2
  pair_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_valid_i && ev_trail_i && pend) |=> res_valid_o);

  // R8
  result_needs_trail_chk: assert property (@(posedge clk) disable iff (!rst_s)
    res_valid_o |-> $past(ev_valid_i && ev_trail_i));

  // R6
  orphan_no_result_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_valid_i && ev_trail_i && !pend) |=> (!res_valid_o && orphan_err_o));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    orphan_err_o |=> orphan_err_o);

  // R9
  width_in_span_chk: assert property (@(posedge clk) disable iff (!rst_s)
    res_valid_o |-> (res_width_o <= SPAN_M1));

endmodule

// File: tb/tb_tot_width_top.sv
`timescale 1ns/1ps
module tb_tot_width_top;
  localparam int     COARSE_W = 13;
  localparam int     FINE_W   = 13;
  localparam int     CLK_FINE = 5000;
  localparam longint MODC     = longint'(1) << COARSE_W;
  localparam longint SPAN     = MODC * CLK_FINE;
  localparam int     OUT_W    = $clog2(SPAN + 1);

  logic                clk = 1'b0;
  logic                rst_n;
  logic                ev_valid_i;
  logic                ev_trail_i;
  logic [COARSE_W-1:0] ev_coarse_i;
  logic [FINE_W-1:0]   ev_fine_i;
  logic                res_valid_o;
  logic [OUT_W-1:0]    res_width_o;
  logic                orphan_err_o;

  tot_width_top #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .CLK_FINE(CLK_FINE)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_valid_i   (ev_valid_i),
    .ev_trail_i   (ev_trail_i),
    .ev_coarse_i  (ev_coarse_i),
    .ev_fine_i    (ev_fine_i),
    .res_valid_o  (res_valid_o),
    .res_width_o  (res_width_o),
    .orphan_err_o (orphan_err_o)
  );

  always #2 clk = ~clk;

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  longint exp_q[$];
  string  tag_q[$];
  bit     pend_m = 1'b0;
  longint lc_m, lf_m;

  function automatic longint exp_width(longint cl, longint fl, longint ct, longint ft);
    longint dc, w;
    dc = (((ct - cl) % MODC) + MODC) % MODC;
    w  = dc * CLK_FINE - ft + fl;
    if (w < 0) w = w + SPAN;
    return w;
  endfunction

  task automatic send_edge(input bit tr, input int c, input int f, input string tag);
    @(negedge clk);
    ev_valid_i  = 1'b1;
    ev_trail_i  = tr;
    ev_coarse_i = COARSE_W'(c);
    ev_fine_i   = FINE_W'(f);
    if (!tr) begin
      pend_m = 1'b1; lc_m = c; lf_m = f;
    end else if (pend_m) begin
      exp_q.push_back(exp_width(lc_m, lf_m, c, f));
      tag_q.push_back(tag);
      pend_m = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_valid_i = 1'b0;
    end
  endtask

  task automatic check_err(input bit exp, input string tag);
    checks++;
    if (orphan_err_o !== exp) begin
      errors++;
      $display("FAIL %s: orphan_err_o=%0b expected %0b", tag, orphan_err_o, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid_o === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6/R8: unexpected result width=%0d expected none", res_width_o);
      end else begin
        longint e;
        string  t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (longint'(res_width_o) != e) begin
          errors++;
          $display("FAIL %s: width=%0d expected %0d", t, res_width_o, e);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; ev_valid_i = 1'b0; ev_trail_i = 1'b0;
    ev_coarse_i = '0; ev_fine_i = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid_o !== 1'b0 || orphan_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b err=%0b expected 0 0", res_valid_o, orphan_err_o);
    end
    rst_n = 1'b1;
    idle(4);
    check_err(1'b0, "R1");

    // R8: masked trailing edge with nothing pending changes nothing
    @(negedge clk);
    ev_valid_i = 1'b0; ev_trail_i = 1'b1; ev_coarse_i = 13'd5; ev_fine_i = 13'd7;
    idle(2);
    check_err(1'b0, "R8");

    // R2 plain pair
    send_edge(1'b0, 100, 300, "R2");
    send_edge(1'b1, 105, 1200, "R2");
    idle(2);
    // R3 wrap across coarse modulus
    send_edge(1'b0, 8190, 10, "R3");
    send_edge(1'b1, 3, 20, "R3");
    idle(1);
    // R4 negative raw, one span added
    send_edge(1'b0, 50, 100, "R4");
    send_edge(1'b1, 50, 900, "R4");
    idle(1);
    // R2 zero width
    send_edge(1'b0, 7, 500, "R2");
    send_edge(1'b1, 7, 500, "R2");
    idle(1);
    // R5 replacement
    send_edge(1'b0, 10, 0, "R5");
    send_edge(1'b0, 20, 0, "R5");
    send_edge(1'b1, 22, 0, "R5");
    idle(1);
    // R9 largest width SPAN-1
    send_edge(1'b0, 0, 4999, "R9");
    send_edge(1'b1, 8191, 0, "R9");
    // R7 back-to-back pulses
    send_edge(1'b0, 200, 40, "R7");
    send_edge(1'b1, 201, 30, "R7");
    send_edge(1'b0, 202, 1000, "R7");
    send_edge(1'b1, 210, 4000, "R7");
    idle(3);
    check_err(1'b0, "R7");

    // R6 orphan trailing edge after pairing cleared the pending state
    send_edge(1'b1, 300, 0, "R6");
    idle(1);
    check_err(1'b1, "R6");
    idle(5);
    check_err(1'b1, "R6");

    // R6 pairing still works after error
    send_edge(1'b0, 400, 100, "R6");
    send_edge(1'b1, 402, 50, "R6");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule